// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block watches 128 general-purpose pins, grouped as four banks of 32. It records rising and falling transitions in a sticky status register for each bank. Each pin passes through a two-flop synchronizer. A transition is recorded only when the pin is configured as an input and the enable for that edge direction is set. Software reads the records and clears them by writing ones.

The status bits drive three registered interrupt lines. Pin 0 of bank 0 has its own line and pin 1 of bank 0 has its own line. All other pins share a third line. While the processor is halted, a transition on an input pin that belongs to a fixed wake set produces a one-cycle wake request.

The register bus is a simple single-cycle write port with a combinational read-data output. Pin direction and the halted flag are plain inputs driven by neighbouring logic.

Top module: `edge_irq_unit`

## Requirements
- R1: The bus decodes the following 9-bit word addresses. Rising-enable for banks 0..3 is at 0x030, 0x034, 0x038 and 0x130. Falling-enable is at 0x03C, 0x040, 0x044 and 0x13C. Edge status is at 0x048, 0x04C, 0x050 and 0x148. A write to an enable address replaces the enable register. `busRdData` returns the addressed register, and 0 for any other address.
- R2: A status bit is set when its synchronised pin goes from 0 to 1, its rising-enable bit is 1 and its `pinDir` bit is 0 (input). Pin p is bit p mod 32 of bank p/32.
- R3: A status bit is set when its synchronised pin goes from 1 to 0, its falling-enable bit is 1 and its `pinDir` bit is 0.
- R4: A pin whose `pinDir` bit is 1 (output) never sets its status bit.
- R5: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R6: If a new edge and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R7: `irqPin0` and `irqPin1` equal the previous cycle's bank-0 status bits 0 and 1.
- R8: `irqShared` equals the previous cycle's OR of bank-0 status bits 31..2 and all status bits of banks 1..3.
- R9: `wakeReq` is a one-cycle pulse. It is raised on the same clock edge that would record a status change when all of these hold: `cpuHalted` is 1, the pin has a transition in either direction, the pin is an input, and the pin is in the wake set. The wake set per bank is 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F. Enables do not gate it.
- R10: A pin change sampled at clock edge n appears in status at edge n+2, and on the interrupt lines at edge n+3.
- R11: While `rstN` is low, all enables, status bits, synchronizer and previous-level state, interrupt lines and `wakeReq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 128 | Raw pin levels, asynchronous |
| pinDir | input | 128 | Per-pin direction, 1 = output |
| cpuHalted | input | 1 | Processor halted flag |
| busAddr | input | 9 | Register word address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| irqPin0 | output | 1 | Interrupt for bank-0 pin 0 |
| irqPin1 | output | 1 | Interrupt for bank-0 pin 1 |
| irqShared | output | 1 | Combined interrupt for all other pins |
| wakeReq | output | 1 | Wake request pulse |

## Verification
Results arrive at different times after a stimulus:
- A pin change sampled at one edge appears in status two edges later.
- The wake pulse appears on that same later edge.
- The interrupt lines follow one edge after the status.
- Register writes show up in read data right after the writing edge.

The bench steps a behavioural model on each rising edge, using a two-entry queue for the synchronizer delay. It compares the model with every output at the falling edge that follows. Directed status reads and wake checks are placed at exactly the cycle counts above. The same-cycle clear is aimed at the edge where the status change lands.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

  localparam int BANK_COUNT    = 4;
  localparam int PINS_PER_BANK = 32;
  localparam int PIN_COUNT     = BANK_COUNT * PINS_PER_BANK;
  localparam int BANK_SEL_W    = $clog2(BANK_COUNT);
  localparam int ADDR_W        = 9;
  localparam int SYNC_DEPTH    = 2;

  localparam logic [ADDR_W-1:0] RISE_BASE = 9'h030;
  localparam logic [ADDR_W-1:0] FALL_BASE = 9'h03C;
  localparam logic [ADDR_W-1:0] STAT_BASE = 9'h048;
  localparam logic [ADDR_W-1:0] LAST_BANK_OFFSET = 9'h100;
  localparam int BANK_STRIDE = 4;

  localparam logic [PIN_COUNT-1:0] WAKE_SET =
    {32'h0012_007F, 32'hEC08_0000, 32'h0020_01FC, 32'h8003_FE1B};

  typedef enum logic [1:0] {
    REG_NONE,
    REG_RISE,
    REG_FALL,
    REG_STAT
  } regKind_e;

  typedef struct packed {
    regKind_e                kind;
    logic [BANK_SEL_W-1:0]   bank;
  } regHit_t;

  typedef struct packed {
    logic [BANK_COUNT-1:0]    loadRise;
    logic [BANK_COUNT-1:0]    loadFall;
    logic [BANK_COUNT-1:0]    clearStat;
    logic [PINS_PER_BANK-1:0] data;
  } ctrlStb_t;

  function automatic logic [ADDR_W-1:0] bankOffset(input int b);
    if (b == BANK_COUNT - 1) return LAST_BANK_OFFSET;
    return ADDR_W'(b * BANK_STRIDE);
  endfunction

  function automatic regHit_t decodeAddr(input logic [ADDR_W-1:0] addr);
    regHit_t hit;
    hit.kind = REG_NONE;
    hit.bank = '0;
    for (int b = 0; b < BANK_COUNT; b++) begin
      if (addr == RISE_BASE + bankOffset(b)) begin
        hit.kind = REG_RISE;
        hit.bank = BANK_SEL_W'(b);
      end
      if (addr == FALL_BASE + bankOffset(b)) begin
        hit.kind = REG_FALL;
        hit.bank = BANK_SEL_W'(b);
      end
      if (addr == STAT_BASE + bankOffset(b)) begin
        hit.kind = REG_STAT;
        hit.bank = BANK_SEL_W'(b);
      end
    end
    return hit;
  endfunction

endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [DEPTH-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '0;
    end else begin
      stageQ[0] <= asyncIn;
      for (int s = 1; s < DEPTH; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[DEPTH-1];

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWrEn,
  input  logic [PINS_PER_BANK-1:0] busWrData,
  input  logic [PIN_COUNT-1:0]     riseFlat,
  input  logic [PIN_COUNT-1:0]     fallFlat,
  input  logic [PIN_COUNT-1:0]     statFlat,
  output ctrlStb_t                 stb,
  output logic [PINS_PER_BANK-1:0] busRdData
);

  regHit_t hit;
  int      sliceLo;

  always_comb begin
    hit     = decodeAddr(busAddr);
    sliceLo = int'(hit.bank) * PINS_PER_BANK;
  end

  always_comb begin
    stb      = '0;
    stb.data = busWrData;
    if (busWrEn) begin
      unique case (hit.kind)
        REG_RISE: stb.loadRise[hit.bank]  = 1'b1;
        REG_FALL: stb.loadFall[hit.bank]  = 1'b1;
        REG_STAT: stb.clearStat[hit.bank] = 1'b1;
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (hit.kind)
      REG_RISE: busRdData = riseFlat[sliceLo +: PINS_PER_BANK];
      REG_FALL: busRdData = fallFlat[sliceLo +: PINS_PER_BANK];
      REG_STAT: busRdData = statFlat[sliceLo +: PINS_PER_BANK];
      default:  busRdData = '0;
    endcase
  end

  // R1: a single write reaches at most one register
  a_r1_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadRise, stb.loadFall, stb.clearStat}));

  // R1: no strobe without a write
  a_r1_no_stray_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |-> ({stb.loadRise, stb.loadFall, stb.clearStat} == '0));

endmodule

// File: rtl/edge_irq_dp.sv
module edge_irq_dp
  import edge_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinSync,
  input  logic [PIN_COUNT-1:0] pinDir,
  input  logic                 cpuHalted,
  input  ctrlStb_t             stb,
  output logic [PIN_COUNT-1:0] riseFlat,
  output logic [PIN_COUNT-1:0] fallFlat,
  output logic [PIN_COUNT-1:0] statFlat,
  output logic                 irqPin0,
  output logic                 irqPin1,
  output logic                 irqShared,
  output logic                 wakeReq
);

  logic [PIN_COUNT-1:0] prevLvl;
  logic [PIN_COUNT-1:0] inputPins;
  logic [PIN_COUNT-1:0] roseNow;
  logic [PIN_COUNT-1:0] fellNow;
  logic [PIN_COUNT-1:0] setBits;

  always_comb begin
    inputPins = ~pinDir;
    roseNow   = pinSync & ~prevLvl;
    fellNow   = ~pinSync & prevLvl;
    setBits   = inputPins & ((roseNow & riseFlat) | (fellNow & fallFlat));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= pinSync;
  end

  for (genvar b = 0; b < BANK_COUNT; b++) begin : g_bank
    localparam int LO = b * PINS_PER_BANK;
    logic [PINS_PER_BANK-1:0] clrMask;

    assign clrMask = stb.clearStat[b] ? stb.data : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        riseFlat[LO +: PINS_PER_BANK] <= '0;
        fallFlat[LO +: PINS_PER_BANK] <= '0;
        statFlat[LO +: PINS_PER_BANK] <= '0;
      end else begin
        if (stb.loadRise[b]) riseFlat[LO +: PINS_PER_BANK] <= stb.data;
        if (stb.loadFall[b]) fallFlat[LO +: PINS_PER_BANK] <= stb.data;
        // an edge arriving in the clearing cycle is kept
        statFlat[LO +: PINS_PER_BANK] <=
          (statFlat[LO +: PINS_PER_BANK] & ~clrMask) | setBits[LO +: PINS_PER_BANK];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPin0   <= 1'b0;
      irqPin1   <= 1'b0;
      irqShared <= 1'b0;
      wakeReq   <= 1'b0;
    end else begin
      irqPin0   <= statFlat[0];
      irqPin1   <= statFlat[1];
      irqShared <= |statFlat[PIN_COUNT-1:2];
      wakeReq   <= cpuHalted && |((roseNow | fellNow) & inputPins & WAKE_SET);
    end
  end

  // R4: an output-direction pin never gains a status bit
  a_r4_output_never_flags: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statFlat & ~$past(statFlat) & $past(pinDir)) == '0));

  // R5: bits fall only in a cycle with a clearing write
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clearStat == '0) |=> (($past(statFlat) & ~statFlat) == '0));

  // R7: dedicated lines track bank-0 bits 0 and 1 one cycle later
  a_r7_irq0_lag: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqPin0 == $past(statFlat[0])));
  a_r7_irq1_lag: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqPin1 == $past(statFlat[1])));

  // R8: shared line needs a pending bit outside the two dedicated ones
  a_r8_shared_source: assert property (@(posedge clk) disable iff (!rstN)
    irqShared |-> $past(|statFlat[PIN_COUNT-1:2]));

  // R9: wake only while halted
  a_r9_wake_needs_halt: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> $past(cpuHalted));

endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
  import edge_irq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [PIN_COUNT-1:0]     pinIn,
  input  logic [PIN_COUNT-1:0]     pinDir,
  input  logic                     cpuHalted,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWrEn,
  input  logic [PINS_PER_BANK-1:0] busWrData,
  output logic [PINS_PER_BANK-1:0] busRdData,
  output logic                     irqPin0,
  output logic                     irqPin1,
  output logic                     irqShared,
  output logic                     wakeReq
);

  logic [PIN_COUNT-1:0] pinSync;
  logic [PIN_COUNT-1:0] riseFlat;
  logic [PIN_COUNT-1:0] fallFlat;
  logic [PIN_COUNT-1:0] statFlat;
  ctrlStb_t             stb;

  edge_irq_sync #(.WIDTH(PIN_COUNT), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .syncOut (pinSync)
  );

  edge_irq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .riseFlat  (riseFlat),
    .fallFlat  (fallFlat),
    .statFlat  (statFlat),
    .stb       (stb),
    .busRdData (busRdData)
  );

  edge_irq_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinSync   (pinSync),
    .pinDir    (pinDir),
    .cpuHalted (cpuHalted),
    .stb       (stb),
    .riseFlat  (riseFlat),
    .fallFlat  (fallFlat),
    .statFlat  (statFlat),
    .irqPin0   (irqPin0),
    .irqPin1   (irqPin1),
    .irqShared (irqShared),
    .wakeReq   (wakeReq)
  );

endmodule

// File: tb/edge_irq_unit_bench.sv
`timescale 1ns/1ps
module edge_irq_unit_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [127:0] pinIn = '0;
  logic [127:0] pinDir = '0;
  logic         cpuHalted = 1'b0;
  logic [8:0]   busAddr = '0;
  logic         busWrEn = 1'b0;
  logic [31:0]  busWrData = '0;
  logic [31:0]  busRdData;
  logic         irqPin0, irqPin1, irqShared, wakeReq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  bit started = 1'b0;

  always #2.5 clk = ~clk;

  edge_irq_unit u_edge_irq_unit (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinDir(pinDir),
    .cpuHalted(cpuHalted), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .irqPin0(irqPin0),
    .irqPin1(irqPin1), .irqShared(irqShared), .wakeReq(wakeReq)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0]  mRise [4];
  logic [31:0]  mFall [4];
  logic [31:0]  mStat [4];
  logic [127:0] pinQ [$];
  logic [127:0] mPrev = '0;
  logic [127:0] mCur;
  logic [127:0] wakeSet;
  logic         mIrq0 = 0, mIrq1 = 0, mIrqX = 0, mWake = 0;
  logic [31:0]  setB, clrB, cb, pb, db;

  initial begin
    for (int b = 0; b < 4; b++) begin
      mRise[b] = '0; mFall[b] = '0; mStat[b] = '0;
    end
    wakeSet = {32'h0012007F, 32'hEC080000, 32'h002001FC, 32'h8003FE1B};
  end

  function automatic logic [8:0] riseAddr(int b); return (b == 3) ? 9'h130 : 9'(9'h030 + 4 * b); endfunction
  function automatic logic [8:0] fallAddr(int b); return (b == 3) ? 9'h13C : 9'(9'h03C + 4 * b); endfunction
  function automatic logic [8:0] statAddr(int b); return (b == 3) ? 9'h148 : 9'(9'h048 + 4 * b); endfunction

  function automatic logic [31:0] modelRead(logic [8:0] a);
    for (int b = 0; b < 4; b++) begin
      if (a == riseAddr(b)) return mRise[b];
      if (a == fallAddr(b)) return mFall[b];
      if (a == statAddr(b)) return mStat[b];
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < 4; b++) begin
        mRise[b] = '0; mFall[b] = '0; mStat[b] = '0;
      end
      pinQ = {};
      pinQ.push_back('0);
      pinQ.push_back('0);
      mPrev = '0;
      mIrq0 = 0; mIrq1 = 0; mIrqX = 0; mWake = 0;
    end else begin
      started = 1'b1;
      pinQ.push_back(pinIn);
      mCur  = pinQ.pop_front();
      mIrq0 = mStat[0][0];
      mIrq1 = mStat[0][1];
      mIrqX = ((mStat[0] & ~32'h3) | mStat[1] | mStat[2] | mStat[3]) != 0;
      mWake = cpuHalted && (((mCur ^ mPrev) & ~pinDir & wakeSet) != 0);
      for (int b = 0; b < 4; b++) begin
        cb = mCur[b*32 +: 32];
        pb = mPrev[b*32 +: 32];
        db = pinDir[b*32 +: 32];
        setB = ~db & ((cb & ~pb & mRise[b]) | (~cb & pb & mFall[b]));
        clrB = (busWrEn && busAddr == statAddr(b)) ? busWrData : 32'h0;
        mStat[b] = (mStat[b] & ~clrB) | setB;
        if (busWrEn && busAddr == riseAddr(b)) mRise[b] = busWrData;
        if (busWrEn && busAddr == fallAddr(b)) mFall[b] = busWrData;
      end
      mPrev = mCur;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && started && !done) begin
      check("R7 irqPin0", 32'(irqPin0), 32'(mIrq0));
      check("R7 irqPin1", 32'(irqPin1), 32'(mIrq1));
      check("R8 irqShared", 32'(irqShared), 32'(mIrqX));
      check("R9 wakeReq", 32'(wakeReq), 32'(mWake));
      check("R1 readback", busRdData, modelRead(busAddr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rd(string tag, logic [8:0] a, logic [31:0] exp);
    busAddr = a;
    #1;
    check(tag, busRdData, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected below 20000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R11: reset state
    rd("R11 status b0 in reset", 9'h048, 32'h0);
    rd("R11 rise b3 in reset", 9'h130, 32'h0);
    check("R11 irq lines in reset", {28'h0, irqPin0, irqPin1, irqShared, wakeReq}, 32'h0);
    rstN = 1'b1;
    idle(2);

    // R1: enable writes and decode
    wr(9'h030, 32'h0000_0011);
    wr(9'h03C, 32'h0000_0002);
    wr(9'h130, 32'h8000_0001);
    wr(9'h040, 32'hA5A5_0000);
    rd("R1 rise b0", 9'h030, 32'h0000_0011);
    rd("R1 fall b0", 9'h03C, 32'h0000_0002);
    rd("R1 rise b3", 9'h130, 32'h8000_0001);
    rd("R1 fall b1", 9'h040, 32'hA5A5_0000);
    rd("R1 rise b1 untouched", 9'h034, 32'h0);
    rd("R1 unmapped", 9'h000, 32'h0);

    // R10 / R2: latency of a rising edge on pin 0
    pinIn[0] = 1'b1;
    idle(2);
    rd("R10 not yet", 9'h048, 32'h0);
    idle(1);
    rd("R2 R10 rise pin0", 9'h048, 32'h1);

    // R3: falling on pin 1 (rise not enabled for it)
    pinIn[1] = 1'b1;
    idle(4);
    rd("R2 rise without enable", 9'h048, 32'h1);
    pinIn[1] = 1'b0;
    idle(4);
    rd("R3 fall pin1", 9'h048, 32'h3);

    // R4: output-direction pin ignored
    pinDir[4] = 1'b1;
    pinIn[4] = 1'b1;
    idle(4);
    rd("R4 output pin", 9'h048, 32'h3);

    // R5: write one to clear
    wr(9'h048, 32'h0);
    rd("R5 zero write", 9'h048, 32'h3);
    wr(9'h048, 32'h1);
    rd("R5 clear bit0", 9'h048, 32'h2);

    // R6: edge arriving on the clearing edge survives
    pinIn[0] = 1'b0;
    idle(4);
    pinIn[0] = 1'b1;
    idle(2);
    wr(9'h048, 32'h3);
    rd("R6 edge wins", 9'h048, 32'h1);

    // R9 / R8: wake on masked input pin while halted
    cpuHalted = 1'b1;
    pinIn[96] = 1'b1;
    idle(3);
    check("R9 wake pulse", 32'(wakeReq), 32'h1);
    rd("R2 bank3 pin0", 9'h148, 32'h1);
    idle(1);
    check("R9 wake one cycle", 32'(wakeReq), 32'h0);
    check("R8 shared raised", 32'(irqShared), 32'h1);

    pinIn[127] = 1'b1;
    idle(3);
    check("R9 outside wake set", 32'(wakeReq), 32'h0);
    rd("R2 bank3 pin31", 9'h148, 32'h8000_0001);

    cpuHalted = 1'b0;
    pinIn[96] = 1'b0;
    idle(3);
    check("R9 not halted", 32'(wakeReq), 32'h0);

    wr(9'h148, 32'hFFFF_FFFF);
    wr(9'h048, 32'hFFFF_FFFF);
    idle(2);
    check("R8 shared cleared", 32'(irqShared), 32'h0);
    check("R7 irq0 cleared", 32'(irqPin0), 32'h0);

    // R3 on bank 1
    pinIn[48] = 1'b1;
    idle(4);
    pinIn[48] = 1'b0;
    idle(4);
    rd("R3 fall bank1", 9'h04C, 32'h0001_0000);
    check("R8 shared from bank1", 32'(irqShared), 32'h1);

    // R11: reset mid-run
    rstN = 1'b0;
    idle(1);
    rd("R11 rise b0 after reset", 9'h030, 32'h0);
    rd("R11 status b1 after reset", 9'h04C, 32'h0);
    check("R11 lines after reset", {28'h0, irqPin0, irqPin1, irqShared, wakeReq}, 32'h0);
    rstN = 1'b1;
    idle(4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule